// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which of a set of message objects (32 by default) a received CAN frame belongs to. Each object holds an identifier, a mask, a format flag (29-bit or 11-bit identifier), a direction flag, a use-mask enable, two mask qualifiers (one for format, one for direction) and a valid flag. Objects are loaded through a simple write port. When the frame-valid strobe is raised, the identifier, format bit and direction bit of the frame are compared against every valid object in parallel. The lowest-numbered object that matches wins.

A single 29-bit identifier field serves both formats. An 11-bit identifier sits in bits 28..18 of that field, so a standard-format object ignores bits 17..0 of both the frame and its own mask. For each object the block keeps a new-data flag and a message-lost flag. The new-data flag is set when a frame is stored into the object and cleared by a read strobe. The message-lost flag is set when a frame lands on data that is still unread, and it is cleared by an explicit clear strobe.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `hit`, `hit_idx`, `new_flags` and `lost_flags` are all zero, and every object is invalid, so no frame is accepted.
- R2: An object whose valid bit is clear never matches, whatever its other fields hold.
- R3: With use-mask clear, an object matches only if all 29 identifier bits it compares, the format bit and the direction bit equal those of the frame.
- R4: A standard-format object (format flag 0) compares only identifier bits 28..18. Bits 17..0 of the frame are ignored.
- R5: With use-mask set, a mask bit of 1 requires the matching identifier bit to be equal, and a mask bit of 0 makes that bit a don't-care.
- R6: With use-mask set, the format bit is compared only when the object's format qualifier is 1.
- R7: With use-mask set, the direction bit is compared only when the object's direction qualifier is 1.
- R8: When several objects match, `hit_idx` reports the lowest object number.
- R9: `hit` is a one-cycle pulse in the cycle after `frm_valid`, with `hit_idx` holding the winning object. When `hit` is 0, `hit_idx` is 0.
- R10: An accepted frame sets `new_flags[n]` of the winning object n. `rd_en` with `rd_idx`=n clears it. If a store and a read of the same object fall in the same cycle, the flag ends at 1.
- R11: A store into an object whose new-data flag is 1 sets `lost_flags[n]`, unless a read of that object falls in the same cycle. `lost_clr` with `lost_clr_idx`=n clears the flag. A set in the same cycle wins over the clear.
- R12: A configuration write takes effect at the clock edge it is sampled on. A frame presented in the same cycle is filtered with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one object |
| cfg_idx | input | 5 | Object number to write |
| cfg_id | input | 29 | Identifier (an 11-bit identifier in bits 28..18) |
| cfg_mask | input | 29 | Acceptance mask, 1 = bit must match |
| cfg_xtd | input | 1 | Object format, 1 = 29-bit identifier |
| cfg_dir | input | 1 | Object direction bit |
| cfg_use_mask | input | 1 | Enables the mask and the qualifiers |
| cfg_fmt_qual | input | 1 | Compare the format bit when masking |
| cfg_dir_qual | input | 1 | Compare the direction bit when masking |
| cfg_valid | input | 1 | Object takes part in filtering |
| frm_valid | input | 1 | Frame strobe |
| frm_id | input | 29 | Frame identifier field |
| frm_xtd | input | 1 | Frame format bit |
| frm_dir | input | 1 | Frame direction bit |
| rd_en | input | 1 | Read strobe, clears a new-data flag |
| rd_idx | input | 5 | Object read |
| lost_clr | input | 1 | Clear strobe for a message-lost flag |
| lost_clr_idx | input | 5 | Object whose lost flag is cleared |
| hit | output | 1 | Frame accepted (pulse) |
| hit_idx | output | 5 | Winning object |
| new_flags | output | 32 | Per-object unread-data flags |
| lost_flags | output | 32 | Per-object message-lost flags |

## Verification
`hit` and `hit_idx` are due one clock edge after the cycle in which `frm_valid` is high. Both flag vectors also change on that same edge, and on the edge that samples a read or clear strobe. The bench drives every input on the falling edge. Its behavioural model updates on the rising edge from the same stable inputs. All outputs are compared with the model on the next falling edge, which is exactly one register after the stimulus. Directed checks with literal expected values sample at that same falling edge. One more falling edge later, the bench confirms that the hit pulse is over.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
   localparam int CAN_ID_W  = 29;
   localparam int CAN_STD_W = 11;

   typedef struct packed {
      logic                valid;
      logic                use_mask;
      logic                fmt_qual;
      logic                dir_qual;
      logic                xtd;
      logic                dir;
      logic [CAN_ID_W-1:0] mask;
      logic [CAN_ID_W-1:0] id;
   } filt_obj_t;
endpackage

// File: rtl/can_obj_match.sv
module can_obj_match
   import can_filt_pkg::*;
(
   input  filt_obj_t           obj,
   input  logic [CAN_ID_W-1:0] frm_id,
   input  logic                frm_xtd,
   input  logic                frm_dir,
   output logic                match
);
   // bits an 11-bit object looks at
   localparam logic [CAN_ID_W-1:0] STD_SEL =
      {{CAN_STD_W{1'b1}}, {(CAN_ID_W-CAN_STD_W){1'b0}}};

   logic [CAN_ID_W-1:0] care;
   logic                id_ok, fmt_ok, dir_ok;

   always_comb begin
      care   = (obj.use_mask ? obj.mask : {CAN_ID_W{1'b1}})
             & (obj.xtd ? {CAN_ID_W{1'b1}} : STD_SEL);
      id_ok  = ((frm_id ^ obj.id) & care) == '0;
      fmt_ok = (obj.use_mask && !obj.fmt_qual) || (frm_xtd == obj.xtd);
      dir_ok = (obj.use_mask && !obj.dir_qual) || (frm_dir == obj.dir);
      match  = obj.valid && id_ok && fmt_ok && dir_ok;
   end
endmodule

// File: rtl/can_low_first.sv
module can_low_first #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   initial assert (N <= (1 << IW)) else $fatal(1, "index too narrow");

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (req[i]) idx = IW'(i);
   end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import can_filt_pkg::*;
#(
   parameter int NUM_OBJ = 32,
   localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [CAN_ID_W-1:0] cfg_id,
   input  logic [CAN_ID_W-1:0] cfg_mask,
   input  logic                cfg_xtd,
   input  logic                cfg_dir,
   input  logic                cfg_use_mask,
   input  logic                cfg_fmt_qual,
   input  logic                cfg_dir_qual,
   input  logic                cfg_valid,
   input  logic                frm_valid,
   input  logic [CAN_ID_W-1:0] frm_id,
   input  logic                frm_xtd,
   input  logic                frm_dir,
   input  logic                rd_en,
   input  logic [IDX_W-1:0]    rd_idx,
   input  logic                lost_clr,
   input  logic [IDX_W-1:0]    lost_clr_idx,
   output logic                hit,
   output logic [IDX_W-1:0]    hit_idx,
   output logic [NUM_OBJ-1:0]  new_flags,
   output logic [NUM_OBJ-1:0]  lost_flags
);
   initial assert (NUM_OBJ >= 2) else $fatal(1, "need at least two objects");
   initial assert (CAN_STD_W < CAN_ID_W) else $fatal(1, "bad id widths");

   filt_obj_t          objs [NUM_OBJ];
   logic [NUM_OBJ-1:0] match_vec;
   logic               any_match, store;
   logic [IDX_W-1:0]   win_idx;

   // object store, written through the configuration port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_OBJ; k++) objs[k] <= '0;
      end else if (cfg_we) begin
         objs[cfg_idx] <= '{valid: cfg_valid, use_mask: cfg_use_mask,
                            fmt_qual: cfg_fmt_qual, dir_qual: cfg_dir_qual,
                            xtd: cfg_xtd, dir: cfg_dir,
                            mask: cfg_mask, id: cfg_id};
      end
   end

   for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cmp
      can_obj_match u_match (
         .obj     (objs[g]),
         .frm_id  (frm_id),
         .frm_xtd (frm_xtd),
         .frm_dir (frm_dir),
         .match   (match_vec[g])
      );
   end

   can_low_first #(.N(NUM_OBJ), .IW(IDX_W)) u_pick (
      .req (match_vec),
      .any (any_match),
      .idx (win_idx)
   );

   assign store = frm_valid && any_match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit     <= 1'b0;
         hit_idx <= '0;
      end else begin
         hit     <= store;
         hit_idx <= store ? win_idx : '0;
      end
   end

   for (genvar g = 0; g < NUM_OBJ; g++) begin : g_flag
      logic here, rd_here, clr_here;
      assign here     = store && (win_idx == IDX_W'(g));
      assign rd_here  = rd_en && (rd_idx == IDX_W'(g));
      assign clr_here = lost_clr && (lost_clr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            new_flags[g]  <= 1'b0;
            lost_flags[g] <= 1'b0;
         end else begin
            new_flags[g]  <= here || (new_flags[g] && !rd_here);
            lost_flags[g] <= (here && new_flags[g] && !rd_here)
                          || (lost_flags[g] && !clr_here);
         end
      end
   end

   // R9
   hit_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(frm_valid));
   // R9
   idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0));
   // R10
   hit_marks_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> new_flags[hit_idx]);
   // R10
   new_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((new_flags & ~$past(new_flags)) != '0) |-> hit);
   // R11
   lost_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lost_flags & ~$past(lost_flags)) != '0) |-> (hit && lost_flags[hit_idx]));
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_xtd = 0, cfg_dir = 0, cfg_use_mask = 0;
   logic        cfg_fmt_qual = 0, cfg_dir_qual = 0, cfg_valid = 0;
   logic [4:0]  cfg_idx = 0, rd_idx = 0, lost_clr_idx = 0;
   logic [28:0] cfg_id = 0, cfg_mask = 0, frm_id = 0;
   logic        frm_valid = 0, frm_xtd = 0, frm_dir = 0, rd_en = 0, lost_clr = 0;
   logic        hit;
   logic [4:0]  hit_idx;
   logic [N-1:0] new_flags, lost_flags;

   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   can_accept_filter dut_i (
      .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_id, .cfg_mask, .cfg_xtd, .cfg_dir,
      .cfg_use_mask, .cfg_fmt_qual, .cfg_dir_qual, .cfg_valid,
      .frm_valid, .frm_id, .frm_xtd, .frm_dir, .rd_en, .rd_idx,
      .lost_clr, .lost_clr_idx, .hit, .hit_idx, .new_flags, .lost_flags);

   // behavioural reference
   logic [28:0] m_id [N], m_mask [N];
   bit m_val [N], m_um [N], m_fq [N], m_dq [N], m_xtd [N], m_dir [N];
   bit [N-1:0] m_new, m_lost;
   bit m_hit;
   int m_idx;

   function automatic bit ref_match(int k);
      if (!m_val[k]) return 0;
      for (int b = 0; b < 29; b++) begin
         if (!m_xtd[k] && b < 18) continue;
         if (m_um[k] && !m_mask[k][b]) continue;
         if (frm_id[b] != m_id[k][b]) return 0;
      end
      if ((!m_um[k] || m_fq[k]) && frm_xtd != m_xtd[k]) return 0;
      if ((!m_um[k] || m_dq[k]) && frm_dir != m_dir[k]) return 0;
      return 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin
            m_val[k] <= 0; m_um[k] <= 0; m_fq[k] <= 0; m_dq[k] <= 0;
            m_xtd[k] <= 0; m_dir[k] <= 0; m_id[k] <= 0; m_mask[k] <= 0;
         end
         m_new <= 0; m_lost <= 0; m_hit <= 0; m_idx <= 0;
      end else begin
         int w;
         bit [N-1:0] nn, ll;
         w = -1;
         if (frm_valid)
            for (int k = N - 1; k >= 0; k--) if (ref_match(k)) w = k;
         nn = m_new; ll = m_lost;
         if (rd_en) nn[rd_idx] = 0;
         if (lost_clr) ll[lost_clr_idx] = 0;
         if (w >= 0) begin
            if (m_new[w] && !(rd_en && int'(rd_idx) == w)) ll[w] = 1;
            nn[w] = 1;
         end
         m_new <= nn; m_lost <= ll;
         m_hit <= (w >= 0);
         m_idx <= (w >= 0) ? w : 0;
         if (cfg_we) begin
            m_val[cfg_idx] <= cfg_valid; m_um[cfg_idx] <= cfg_use_mask;
            m_fq[cfg_idx] <= cfg_fmt_qual; m_dq[cfg_idx] <= cfg_dir_qual;
            m_xtd[cfg_idx] <= cfg_xtd; m_dir[cfg_idx] <= cfg_dir;
            m_id[cfg_idx] <= cfg_id; m_mask[cfg_idx] <= cfg_mask;
         end
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 hit vs model", 64'(hit), 64'(m_hit));
         chk("R8 hit_idx vs model", 64'(hit_idx), 64'(m_idx));
         chk("R10 new_flags vs model", 64'(new_flags), 64'(m_new));
         chk("R11 lost_flags vs model", 64'(lost_flags), 64'(m_lost));
      end
   end

   task automatic cfg(int idx, logic [28:0] id, logic [28:0] mask, bit xtd, bit dir,
                      bit um, bit fq, bit dq, bit val);
      cfg_idx = 5'(idx); cfg_id = id; cfg_mask = mask; cfg_xtd = xtd; cfg_dir = dir;
      cfg_use_mask = um; cfg_fmt_qual = fq; cfg_dir_qual = dq; cfg_valid = val;
      cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
   endtask

   // drives one frame; returns at the falling edge where the result is visible
   task automatic send(logic [28:0] id, bit xtd, bit dir);
      frm_id = id; frm_xtd = xtd; frm_dir = dir; frm_valid = 1;
      @(negedge clk);
      frm_valid = 0; rd_en = 0; lost_clr = 0; cfg_we = 0;
   endtask

   task automatic expect_hit(string tag, bit eh, int ei);
      chk(tag, 64'(hit), 64'(eh));
      chk(tag, 64'(hit_idx), 64'(ei));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      expect_hit("R1 reset", 0, 0);
      chk("R1 reset flags", 64'(new_flags | lost_flags), 0);
      send(29'h1234567, 1, 0);
      expect_hit("R1 no object valid", 0, 0);

      // R3 exact extended object
      cfg(5, 29'h1234567, 0, 1, 0, 0, 0, 0, 1);
      send(29'h1234567, 1, 0);
      expect_hit("R3 exact match", 1, 5);
      @(negedge clk);
      expect_hit("R9 pulse ends", 0, 0);
      send(29'h1234566, 1, 0);
      expect_hit("R3 low bit differs", 0, 0);
      send(29'h1234567, 0, 0);
      expect_hit("R3 format differs", 0, 0);
      send(29'h1234567, 1, 1);
      expect_hit("R3 direction differs", 0, 0);

      // R4 standard object ignores bits 17..0
      cfg(7, 29'h123 << 18, 0, 0, 0, 0, 0, 0, 1);
      send((29'h123 << 18) | 29'h3FFFF, 0, 0);
      expect_hit("R4 low bits ignored", 1, 7);
      send(29'h124 << 18, 0, 0);
      expect_hit("R4 top bits compared", 0, 0);

      // R2 invalid object
      cfg(7, 29'h123 << 18, 0, 0, 0, 0, 0, 0, 0);
      send(29'h123 << 18, 0, 0);
      expect_hit("R2 invalid object", 0, 0);

      // R5/R6/R7 masking
      cfg(10, 29'h00000F0, 29'h1FFFFF0F, 1, 0, 1, 0, 0, 1);
      send(29'h0000050, 1, 1);
      expect_hit("R5 masked bits ignored, R7 dir not qualified", 1, 10);
      send(29'h0000051, 1, 0);
      expect_hit("R5 mask bit set compared", 0, 0);
      send(29'h00000A0, 0, 0);
      expect_hit("R6 format not qualified", 1, 10);
      cfg(10, 29'h00000F0, 29'h1FFFFF0F, 1, 0, 1, 1, 0, 1);
      send(29'h00000A0, 0, 0);
      expect_hit("R6 format qualified", 0, 0);
      cfg(10, 29'h00000F0, 29'h1FFFFF0F, 1, 0, 1, 1, 1, 1);
      send(29'h00000A0, 1, 1);
      expect_hit("R7 direction qualified", 0, 0);

      // R8 priority
      cfg(20, 29'h0ABCDEF, 0, 1, 0, 0, 0, 0, 1);
      send(29'h0ABCDEF, 1, 0);
      expect_hit("R8 single match", 1, 20);
      cfg(3, 29'h0ABCDEF, 0, 1, 0, 0, 0, 0, 1);
      send(29'h0ABCDEF, 1, 0);
      expect_hit("R8 lowest wins", 1, 3);

      // R11 / R10 flags on object 5
      chk("R10 new set", 64'(new_flags[5]), 1);
      chk("R11 lost clear", 64'(lost_flags[5]), 0);
      send(29'h1234567, 1, 0);
      chk("R11 lost set on overwrite", 64'(lost_flags[5]), 1);
      rd_en = 1; rd_idx = 5;
      @(negedge clk);
      rd_en = 0;
      chk("R10 read clears new", 64'(new_flags[5]), 0);
      chk("R11 read keeps lost", 64'(lost_flags[5]), 1);
      lost_clr = 1; lost_clr_idx = 5;
      @(negedge clk);
      lost_clr = 0;
      chk("R11 clear", 64'(lost_flags[5]), 0);
      send(29'h1234567, 1, 0);
      rd_en = 1; rd_idx = 5;
      send(29'h1234567, 1, 0);
      chk("R10 store beats read", 64'(new_flags[5]), 1);
      chk("R11 read same cycle no loss", 64'(lost_flags[5]), 0);
      lost_clr = 1; lost_clr_idx = 5;
      send(29'h1234567, 1, 0);
      chk("R11 set beats clear", 64'(lost_flags[5]), 1);

      // R12 config in same cycle as frame
      cfg_idx = 7; cfg_id = 29'h123 << 18; cfg_mask = 0; cfg_xtd = 0; cfg_dir = 0;
      cfg_use_mask = 0; cfg_fmt_qual = 0; cfg_dir_qual = 0; cfg_valid = 1; cfg_we = 1;
      send(29'h123 << 18, 0, 0);
      expect_hit("R12 old config used", 0, 0);
      send(29'h123 << 18, 0, 0);
      expect_hit("R12 new config used", 1, 7);

      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule